// File: doc/BRIEF.md
# Dual-Threshold Strip Hit Sparsifier

The block sits behind the comparator bank of a multi-channel silicon strip readout. Each strip has two comparator bits, one set high enough to keep noise hits rare and one set lower to recover charge shared with neighbouring strips. On every readout tick (a slow strobe at roughly a tenth of the shaping time) the block samples both bits of every strip and finds rising and falling edges. It keeps every high-threshold edge. It keeps a low-threshold edge only when a high-threshold edge occurs on a directly adjacent strip within a window of ticks around it.

Amplitude is never digitised. A pulse is described by the time stamps of its leading and trailing edges, and the difference between them is the time over threshold. Kept edges become words that carry strip index, threshold, edge direction, a truncation flag and a 13-bit tick stamp. They are serialised in a fixed order into a FIFO that is read through a valid/ready port. A spill-start pulse clears the stamp counter and the per-spill state.

Low-threshold edges wait in a per-strip delay line of `WIN` ticks, so a high-threshold edge that arrives up to `WIN` ticks later can still qualify them. The ticks must be spaced at least `2*NCH+1` clock cycles apart, so that one tick's edges are fully serialised before the next tick.

Top module: `strip_hit_sparsifier`

## Requirements
- R1: A 13-bit stamp counter is cleared by `spill_start` and advances by one on each `tick`. Edges found on a tick carry the counter value from before that tick's increment, so the first tick of a spill has stamp 0. A `tick` in the same cycle as `spill_start` is ignored.
- R2: Every change of a strip's high comparator between two consecutive ticks, 0 to 1 or 1 to 0, produces exactly one output word marked as high threshold.
- R3: A low-comparator edge found at tick t on strip c is kept only if a high-comparator edge occurs on strip c-1 or c+1 at some tick from t-WIN to t+WIN within the same spill. A kept edge is emitted at tick t+WIN with stamp t. Any other low-comparator edge is dropped.
- R4: Neighbour checks do not wrap: strip 0 looks only at strip 1, and strip NCH-1 looks only at strip NCH-2. A strip's own high-comparator edges never qualify its low-comparator edges.
- R5: Word layout: bits [12:0] hold the stamp and bits [CH_W+12:13] the strip index. Bit CH_W+13 is 1 for a falling edge and 0 for a rising edge. Bit CH_W+14 is 1 for the low threshold. Bit CH_W+15 is 1 for a truncated edge.
- R6: Words from one tick are written in ascending strip order, with a strip's high edge before its low edge. They are written one per clock, starting in the cycle after the tick.
- R7: A falling edge is marked truncated when its comparator has shown no rising edge since the last spill start.
- R8: A word that meets a full FIFO is discarded. In that case `drop_cnt` is incremented (saturating) and `overflow` is set. Both are cleared by reset and by `spill_start`, and both are zero after reset.
- R9: `rd_valid` is high exactly while the FIFO holds a word, and a word leaves on a cycle with `rd_valid` and `rd_ready` both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds. `spill_start` does not clear stored words, and `rd_valid` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_start | input | 1 | Start of a beam spill; clears stamp, history and drop state |
| tick | input | 1 | Readout sample strobe, one cycle wide |
| hi_cmp | input | NCH | High-threshold comparator bits, one per strip |
| lo_cmp | input | NCH | Low-threshold comparator bits, one per strip |
| rd_ready | input | 1 | Consumer accepts the presented word |
| rd_valid | output | 1 | A word is presented |
| rd_data | output | CH_W+16 | Edge word (layout in R5) |
| overflow | output | 1 | Sticky: a word was lost this spill |
| drop_cnt | output | DROP_W | Count of lost words this spill |

## Verification
The bench builds the block with 8 strips, a window of 2 ticks and a 16-word FIFO. With 8 strips both array ends and the inner strips are exercised in short directed patterns. A window of 2 puts the inside edge of the window (2 ticks late) and the first tick outside it (3 ticks late) within a few ticks. Because one tick can emit at most 16 words, a FIFO drained between ticks never overflows. Two dense ticks with the reader stalled fill the FIFO and force exact, predictable drops.

// File: rtl/shp_pkg.sv
package shp_pkg;
   localparam int TS_W = 13;
   typedef logic [TS_W-1:0] ts_t;
   typedef struct packed {
      logic fall;
      logic trunc;
   } edge_attr_t;
endpackage

// File: rtl/shp_fifo.sv
module shp_fifo #(
   parameter int W     = 19,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rd_data = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_en && !full) wp <= wp + 1'b1;
         if (rd_en && !empty) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/shp_edge_qual.sv
module shp_edge_qual
   import shp_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int WIN  = 2,
   localparam int NSLOT = 2 * NCH,
   localparam int HLEN  = 2 * WIN
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   spill_start,
   input  logic [NCH-1:0]         hi_cmp,
   input  logic [NCH-1:0]         lo_cmp,
   output logic [NSLOT-1:0]       slot_v,
   output edge_attr_t [NSLOT-1:0] slot_attr
);
   logic [NCH-1:0] hi_prev, lo_prev, seen_hi, seen_lo;
   logic [NCH-1:0] hi_rise, hi_fall, lo_rise, lo_fall, hi_ev, lo_ev, nb_any;

   assign hi_rise = hi_cmp & ~hi_prev;
   assign hi_fall = ~hi_cmp & hi_prev;
   assign lo_rise = lo_cmp & ~lo_prev;
   assign lo_fall = ~lo_cmp & lo_prev;
   assign hi_ev   = hi_rise | hi_fall;
   assign lo_ev   = lo_rise | lo_fall;

   // comparator history survives a spill start; rising-edge memory does not
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_prev <= '0;
         lo_prev <= '0;
         seen_hi <= '0;
         seen_lo <= '0;
      end else if (spill_start) begin
         seen_hi <= '0;
         seen_lo <= '0;
      end else if (tick) begin
         hi_prev <= hi_cmp;
         lo_prev <= lo_cmp;
         seen_hi <= seen_hi | hi_rise;
         seen_lo <= seen_lo | lo_rise;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [HLEN-1:0] hist;   // bit k: high edge k+1 ticks ago
      logic [WIN-1:0]  dly_v;  // stage k: low edge k+1 ticks ago
      edge_attr_t      dly_a [WIN];
      logic            left_q, right_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist  <= '0;
            dly_v <= '0;
            for (int k = 0; k < WIN; k++) dly_a[k] <= '0;
         end else if (spill_start) begin
            hist  <= '0;
            dly_v <= '0;
            for (int k = 0; k < WIN; k++) dly_a[k] <= '0;
         end else if (tick) begin
            hist <= {hist[HLEN-2:0], hi_ev[c]};
            for (int k = WIN - 1; k > 0; k--) begin
               dly_v[k] <= dly_v[k-1];
               dly_a[k] <= dly_a[k-1];
            end
            dly_v[0] <= lo_ev[c];
            dly_a[0] <= '{fall: lo_fall[c], trunc: lo_fall[c] & ~seen_lo[c]};
         end
      end

      assign nb_any[c] = hi_ev[c] | (|hist);

      if (c > 0) begin : g_left
         assign left_q = nb_any[c-1];
      end else begin : g_no_left
         assign left_q = 1'b0;
      end
      if (c < NCH - 1) begin : g_right
         assign right_q = nb_any[c+1];
      end else begin : g_no_right
         assign right_q = 1'b0;
      end

      assign slot_v[2*c]      = hi_ev[c];
      assign slot_attr[2*c]   = '{fall: hi_fall[c], trunc: hi_fall[c] & ~seen_hi[c]};
      assign slot_v[2*c+1]    = dly_v[WIN-1] & (left_q | right_q);
      assign slot_attr[2*c+1] = dly_a[WIN-1];
   end
endmodule

// File: rtl/shp_scan.sv
module shp_scan
   import shp_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int WIN    = 2,
   parameter int DROP_W = 16,
   localparam int NSLOT  = 2 * NCH,
   localparam int SEL_W  = $clog2(NSLOT),
   localparam int CH_W   = $clog2(NCH),
   localparam int WORD_W = CH_W + 3 + TS_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick,
   input  logic                   spill_start,
   input  logic [NSLOT-1:0]       slot_v,
   input  edge_attr_t [NSLOT-1:0] slot_attr,
   input  logic                   fifo_full,
   output logic                   wr_en,
   output logic [WORD_W-1:0]      wr_data,
   output ts_t                    ts_now,
   output logic                   overflow,
   output logic [DROP_W-1:0]      drop_cnt
);
   logic [NSLOT-1:0]       pend_v;
   edge_attr_t [NSLOT-1:0] pend_a;
   ts_t                    cap_ts, stamp;
   logic [SEL_W-1:0]       sel;
   logic                   any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ts_now <= '0;
      else if (spill_start) ts_now <= '0;
      else if (tick)        ts_now <= ts_now + 1'b1;
   end

   // lowest pending slot wins: ascending strip, high before low
   always_comb begin
      sel = '0;
      any = 1'b0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (pend_v[i]) begin
            sel = SEL_W'(i);
            any = 1'b1;
         end
      end
   end

   assign stamp   = sel[0] ? cap_ts - ts_t'(WIN) : cap_ts;
   assign wr_data = {pend_a[sel].trunc, sel[0], pend_a[sel].fall, sel[SEL_W-1:1], stamp};
   assign wr_en   = any & ~fifo_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v   <= '0;
         pend_a   <= '0;
         cap_ts   <= '0;
         overflow <= 1'b0;
         drop_cnt <= '0;
      end else if (spill_start) begin
         pend_v   <= '0;
         overflow <= 1'b0;
         drop_cnt <= '0;
      end else if (tick) begin
         pend_v <= slot_v;
         pend_a <= slot_attr;
         cap_ts <= ts_now;
      end else if (any) begin
         pend_v[sel] <= 1'b0;
         if (fifo_full) begin
            overflow <= 1'b1;
            if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/strip_hit_sparsifier.sv
module strip_hit_sparsifier
   import shp_pkg::*;
#(
   parameter int NCH        = 8,
   parameter int WIN        = 2,
   parameter int FIFO_DEPTH = 16,
   parameter int DROP_W     = 16,
   localparam int CH_W   = $clog2(NCH),
   localparam int WORD_W = CH_W + 3 + TS_W,
   localparam int NSLOT  = 2 * NCH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spill_start,
   input  logic              tick,
   input  logic [NCH-1:0]    hi_cmp,
   input  logic [NCH-1:0]    lo_cmp,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              overflow,
   output logic [DROP_W-1:0] drop_cnt
);
   if (NCH < 2) begin : g_bad_nch
      $error("strip_hit_sparsifier: NCH must be at least 2");
   end
   if (WIN < 1 || 2 * WIN >= (1 << TS_W)) begin : g_bad_win
      $error("strip_hit_sparsifier: WIN out of range");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("strip_hit_sparsifier: FIFO_DEPTH must be a power of two >= 2");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("strip_hit_sparsifier: DROP_W must be positive");
   end

   logic [NSLOT-1:0]       slot_v;
   edge_attr_t [NSLOT-1:0] slot_attr;
   logic                   wr_en, fifo_full, fifo_empty;
   logic [WORD_W-1:0]      wr_data;
   ts_t                    ts_now;

   shp_edge_qual #(.NCH(NCH), .WIN(WIN)) u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .spill_start (spill_start),
      .hi_cmp      (hi_cmp),
      .lo_cmp      (lo_cmp),
      .slot_v      (slot_v),
      .slot_attr   (slot_attr)
   );

   shp_scan #(.NCH(NCH), .WIN(WIN), .DROP_W(DROP_W)) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .spill_start (spill_start),
      .slot_v      (slot_v),
      .slot_attr   (slot_attr),
      .fifo_full   (fifo_full),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .ts_now      (ts_now),
      .overflow    (overflow),
      .drop_cnt    (drop_cnt)
   );

   shp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_valid & rd_ready),
      .rd_data (rd_data),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   assign rd_valid = ~fifo_empty;
endmodule

// File: rtl/shp_chk.sv
module shp_chk #(
   parameter int WORD_W = 19,
   parameter int DROP_W = 16,
   parameter int TS_W   = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spill_start,
   input logic              tick,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic              fifo_full,
   input logic              overflow,
   input logic [WORD_W-1:0] rd_data,
   input logic [DROP_W-1:0] drop_cnt,
   input logic [TS_W-1:0]   ts
);
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R9

   AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_full && !spill_start |=> $stable(drop_cnt)); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !spill_start |=> overflow); // R8

   AST_OVF_HAS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> drop_cnt != '0); // R8

   AST_SPILL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      spill_start |=> ts == '0 && !overflow && drop_cnt == '0); // R1

   AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !spill_start |=> ts == $past(ts) + 1'b1); // R1

   AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !spill_start |=> $stable(ts)); // R1
endmodule

bind strip_hit_sparsifier shp_chk #(
   .WORD_W (WORD_W),
   .DROP_W (DROP_W),
   .TS_W   (shp_pkg::TS_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spill_start (spill_start),
   .tick        (tick),
   .rd_valid    (rd_valid),
   .rd_ready    (rd_ready),
   .fifo_full   (fifo_full),
   .overflow    (overflow),
   .rd_data     (rd_data),
   .drop_cnt    (drop_cnt),
   .ts          (ts_now)
);

// File: tb/tb_strip_hit_sparsifier.sv
`timescale 1ns/1ps
module tb_strip_hit_sparsifier;
   localparam int NCH = 8, WIN = 2, DEPTH = 16, DROP_W = 16;
   localparam int CH_W = $clog2(NCH), WORD_W = CH_W + 16, TICKP = 48;

   logic clk = 1'b0, rst_n = 1'b0, spill_start = 1'b0, tick = 1'b0, rd_ready = 1'b0;
   logic [NCH-1:0] hi_cmp = '0, lo_cmp = '0;
   logic rd_valid, overflow;
   logic [WORD_W-1:0] rd_data;
   logic [DROP_W-1:0] drop_cnt;

   strip_hit_sparsifier #(.NCH(NCH), .WIN(WIN), .FIFO_DEPTH(DEPTH), .DROP_W(DROP_W)) dut (
      .clk(clk), .rst_n(rst_n), .spill_start(spill_start), .tick(tick),
      .hi_cmp(hi_cmp), .lo_cmp(lo_cmp), .rd_ready(rd_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow), .drop_cnt(drop_cnt));

   always #5 clk = ~clk;

   int nchk = 0, nfail = 0, popped = 0, exp_drop = 0, m_k = 0;
   bit done = 0, hold_pend = 0;
   logic [WORD_W-1:0] held_w, exp_q[$];
   logic [NCH-1:0] m_hp = '0, m_lp = '0, m_sh = '0, m_sl = '0;
   logic [NCH-1:0] m_hev [64], m_lev [64], m_lfall [64], m_ltr [64];

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   function automatic logic [WORD_W-1:0] mkw(logic tr, logic lo, logic fa, int ch, int ts);
      return {tr, lo, fa, CH_W'(ch), 13'(ts)};
   endfunction

   task automatic push(logic [WORD_W-1:0] w);
      if (exp_q.size() >= DEPTH) exp_drop++;
      else exp_q.push_back(w);
   endtask

   // reference: R1 stamps, R2 high edges, R3/R4 neighbour window, R6 order, R7 truncation
   task automatic do_tick(logic [NCH-1:0] h, logic [NCH-1:0] l);
      logic [NCH-1:0] hr, hf, lr, lf;
      int s, j;
      logic q;
      hr = h & ~m_hp; hf = ~h & m_hp; lr = l & ~m_lp; lf = ~l & m_lp;
      s = m_k % 64;
      m_hev[s] = hr | hf; m_lev[s] = lr | lf; m_lfall[s] = lf; m_ltr[s] = lf & ~m_sl;
      for (int c = 0; c < NCH; c++) begin
         if (hr[c] || hf[c]) push(mkw(hf[c] & ~m_sh[c], 1'b0, hf[c], c, m_k));
         if (m_k >= WIN) begin
            j = (m_k - WIN) % 64;
            if (m_lev[j][c]) begin
               q = 1'b0;
               for (int t = m_k - 2 * WIN; t <= m_k; t++) begin
                  if (t >= 0) begin
                     if (c > 0 && m_hev[t % 64][c-1]) q = 1'b1;
                     if (c < NCH - 1 && m_hev[t % 64][c+1]) q = 1'b1;
                  end
               end
               if (q) push(mkw(m_ltr[j][c], 1'b1, m_lfall[j][c], c, m_k - WIN));
            end
         end
      end
      m_sh = m_sh | hr; m_sl = m_sl | lr; m_hp = h; m_lp = l; m_k++;
      @(negedge clk); hi_cmp = h; lo_cmp = l; tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic do_spill();
      @(negedge clk); spill_start = 1'b1;
      @(negedge clk); spill_start = 1'b0;
      m_k = 0; m_sh = '0; m_sl = '0;
   endtask

   task automatic drain(int n, string tag);
      logic [WORD_W-1:0] e;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (hold_pend) chk(rd_valid && rd_data == held_w, "R9 hold", 32'(rd_data), 32'(held_w));
         hold_pend = 0;
         rd_ready = ($urandom % 4) != 0;
         if (rd_valid) begin
            if (rd_ready) begin
               popped++;
               if (exp_q.size() == 0) chk(0, {"R5 unexpected word ", tag}, 32'(rd_data), 0);
               else begin
                  e = exp_q.pop_front();
                  chk(rd_data == e, {"R5 ", tag}, 32'(rd_data), 32'(e));
               end
            end else begin
               hold_pend = 1; held_w = rd_data;
            end
         end
      end
      @(negedge clk); rd_ready = 1'b0; hold_pend = 0;
   endtask

   task automatic run(logic [NCH-1:0] h, logic [NCH-1:0] l, string tag);
      do_tick(h, l);
      drain(TICKP, tag);
   endtask

   task automatic idle_tick(logic [NCH-1:0] h, logic [NCH-1:0] l);
      do_tick(h, l);
      repeat (TICKP) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired act=1 exp=0");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [NCH-1:0] rh, rx;
      void'($urandom(32'h5eed_1234));
      repeat (5) @(negedge clk);
      chk(rd_valid == 0, "R9 reset valid", 32'(rd_valid), 0);
      chk(overflow == 0, "R8 reset overflow", 32'(overflow), 0);
      chk(drop_cnt == 0, "R8 reset drop", 32'(drop_cnt), 0);
      rst_n = 1'b1;
      do_spill();

      // R2 and R1: one high pulse, stamps 1 and 3
      popped = 0;
      run('0, '0, "R1"); run(8'h08, '0, "R2"); run(8'h08, '0, "R2"); run('0, '0, "R2 R1");
      chk(popped == 2, "R2 word count", popped, 2);

      // R3 inside window (hi two ticks late), R6 order at tick 3
      do_spill(); popped = 0;
      run('0, '0, "R3"); run('0, 8'h02, "R3"); run('0, 8'h02, "R3");
      run(8'h04, 8'h02, "R6 R3"); run(8'h04, 8'h02, "R3"); run(8'h04, 8'h02, "R3");
      run('0, '0, "R3"); run('0, '0, "R3"); run('0, '0, "R3");
      chk(popped == 4, "R3 in-window count", popped, 4);

      // R3 outside window (hi three ticks late): low edges dropped
      do_spill(); popped = 0;
      run('0, '0, "R3"); run('0, 8'h20, "R3"); run('0, 8'h20, "R3"); run('0, 8'h20, "R3");
      for (int i = 0; i < 4; i++) run(8'h40, 8'h20, "R3");
      for (int i = 0; i < 4; i++) run(8'h40, '0, "R3");
      for (int i = 0; i < 3; i++) run('0, '0, "R3");
      chk(popped == 2, "R3 out-of-window count", popped, 2);

      // R4 ends do not see each other
      do_spill(); popped = 0;
      run('0, '0, "R4"); run(8'h80, 8'h01, "R4");
      for (int i = 0; i < 4; i++) run(8'h81, 8'h81, "R4");
      chk(popped == 2, "R4 no-wrap count", popped, 2);

      // R7 pulses already high at spill start
      do_spill(); popped = 0;
      run(8'h81, 8'h81, "R7"); run(8'h02, '0, "R7"); run('0, '0, "R7");
      run('0, '0, "R7"); run('0, '0, "R7");
      chk(popped == 5, "R7 truncation count", popped, 5);

      // random traffic
      do_spill(); rh = '0; rx = '0;
      for (int i = 0; i < 150; i++) begin
         for (int c = 0; c < NCH; c++) begin
            if ($urandom % 6 == 0) rh[c] = ~rh[c];
            if ($urandom % 5 == 0) rx[c] = ~rx[c];
         end
         run(rh, rh | rx, "R2 R3 R6 random");
      end
      run('0, '0, "random"); run('0, '0, "random"); run('0, '0, "random");
      chk(drop_cnt == 0, "R8 no drop when drained", 32'(drop_cnt), 0);

      // R8 overflow with reader stalled
      do_spill(); exp_drop = 0;
      idle_tick('0, '0); idle_tick('1, '1); idle_tick('0, '1);
      idle_tick('1, '1); idle_tick('0, '0);
      chk(drop_cnt == DROP_W'(exp_drop), "R8 drop count", 32'(drop_cnt), 32'(exp_drop));
      chk(overflow == 1, "R8 overflow set", 32'(overflow), 1);
      drain(80, "R8 survivors");
      chk(exp_q.size() == 0, "R9 all words read", exp_q.size(), 0);
      do_spill();
      @(negedge clk);
      chk(overflow == 0, "R8 overflow cleared", 32'(overflow), 0);
      chk(drop_cnt == 0, "R8 drop cleared", 32'(drop_cnt), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule